// File: doc/BRIEF.md
# Power-On Reset Supervisor with Integrating Glitch Filter

This block watches a stream of digitized supply-voltage samples and drives an active-low reset for the logic that the supply feeds. The reset stays asserted while the supply sits below a programmable trip level. When the supply reaches that level, a programmable hold timer runs, and the reset is released only once the full hold period has gone by. The trip level is an input. It is normally set to nine tenths of the regulated value.

Once the reset has been released, short disturbances must not pull it low again. The block has no hysteresis, so the trip level is the same in both directions. A leaky accumulator instead sums how deep each under-level sample falls, and the reset is tripped only when that sum reaches a programmable limit. A deep, short dip can trip the reset, and so can a shallow, long one. A brief, shallow dip cannot.

Top module: `por_supervisor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives reset_n low and clears the hold timer and the dip accumulator. After reset, a released supervisor starts from an accumulator of zero.
- R2: While the supervisor is holding (after reset, or after a trip), reset_n stays low for as long as valid samples remain below the trip level or no valid sample arrives.
- R3: In the holding state, a valid sample at or above the trip level starts the hold timer with the length on hold_cycles at that edge. A length of 0 is treated as 1. reset_n rises exactly that many clock edges after the edge that took the starting sample.
- R4: While the hold timer runs, a valid sample below the trip level returns the block to the holding state with reset_n low. The next sample at or above the level restarts a full hold period.
- R5: A sample counts as below the level only when sample < threshold, as unsigned numbers. A sample equal to the threshold counts as above. The same comparison is used for rising and for falling supply.
- R6: While released, each valid below-level sample adds (threshold − sample) to the accumulator. Each valid sample at or above the level subtracts DECAY (default 1), with a floor at zero. Cycles with sample_valid low leave the accumulator unchanged.
- R7: When a valid below-level sample brings the accumulator to a value greater than or equal to the limit, reset_n goes low after that edge, the accumulator is cleared, and the block returns to holding.
- R8: The accumulator limit is taken from trip_limit on the edge that releases the reset and stays fixed while the reset is released. The hold length is fixed once the timer starts.
- R9: The accumulator saturates at its all-ones value instead of wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking a new voltage sample |
| sample | input | SAMPLE_W (12) | Digitized supply voltage, unsigned |
| threshold | input | SAMPLE_W (12) | Trip level, unsigned |
| hold_cycles | input | TIMER_W (16) | Hold period in clock cycles before release |
| trip_limit | input | ACC_W (18) | Accumulated dip depth that trips the reset |
| reset_n | output | 1 | Active-low reset output |

## Verification
The assertions take for granted that sample_valid and the sample are clean levels that are defined on every clock edge. They also assume that DECAY is at least one and that the accumulator is at least as wide as a sample. They treat the threshold as constant within a hold or released interval, because a moving threshold changes the depth that is added, and the monotonic-accumulator properties would then describe a different input. The stimulus changes the threshold only while the block is holding. It changes hold_cycles and trip_limit in the middle of an interval only in the tests that check these values are latched.

// File: rtl/por_pkg.sv
package por_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_TIMER_W  = 16;
    localparam int DEF_ACC_W    = 18;
    localparam int DEF_DECAY    = 1;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_TIMING = 2'd1,
        ST_RUN    = 2'd2
    } por_state_e;

    typedef struct packed {
        logic tmr_start;
        logic tmr_run;
        logic integ_en;
        logic integ_clr;
    } por_cmd_t;

    // Control strobes derived from the current state and the qualified comparison
    function automatic por_cmd_t cmd_of(por_state_e st, logic valid_above);
        por_cmd_t c;
        c.tmr_start = (st == ST_HOLD) && valid_above;
        c.tmr_run   = (st == ST_TIMING);
        c.integ_en  = (st == ST_RUN);
        c.integ_clr = (st != ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/por_hold_timer.sv
module por_hold_timer
    import por_pkg::*;
#(
    parameter int TIMER_W = DEF_TIMER_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [TIMER_W-1:0] length,
    output logic               done
);
    localparam int EXT_W = TIMER_W + 1;

    logic [TIMER_W-1:0] len_q;
    logic [TIMER_W-1:0] cnt;
    logic [EXT_W-1:0]   cnt_next_ext;

    assign cnt_next_ext = EXT_W'(cnt) + EXT_W'(1);
    // Zero length behaves as one cycle: cnt+1 >= 0 holds at once
    assign done = run && (cnt_next_ext >= EXT_W'(len_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            cnt   <= '0;
        end else if (start) begin
            len_q <= length;
            cnt   <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_steps_R3: assert property (@(posedge clk) disable iff (rst)
        run && !start |=> cnt == $past(cnt) + 1'b1);

    assert_len_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !start |=> len_q == $past(len_q));

endmodule

// File: rtl/por_dip_integrator.sv
module por_dip_integrator
    import por_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int ACC_W    = DEF_ACC_W,
    parameter int DECAY    = DEF_DECAY
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic                valid,
    input  logic                below,
    input  logic [SAMPLE_W-1:0] depth,
    input  logic [ACC_W-1:0]    limit,
    output logic                trip
);
    localparam int              SUM_W   = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] DEC     = ACC_W'(DECAY);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] lim_q;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] acc_up;
    logic [ACC_W-1:0] acc_dn;

    always_comb begin
        sum    = SUM_W'(acc) + SUM_W'(depth);
        acc_up = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
        acc_dn = (acc > DEC) ? (acc - DEC) : '0;
        trip   = en && valid && below && (acc_up >= lim_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            lim_q <= '0;
        end else if (clr) begin
            acc   <= '0;
            lim_q <= limit;
        end else if (en && valid) begin
            if (below) acc <= trip ? '0 : acc_up;
            else       acc <= acc_dn;
        end
    end

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        en && valid && below && !trip |=> acc >= $past(acc));

    assert_decay_down_R6: assert property (@(posedge clk) disable iff (rst)
        en && valid && !below |=> acc <= $past(acc));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        en && !valid |=> acc == $past(acc));

    assert_trip_clears_R7: assert property (@(posedge clk) disable iff (rst)
        trip |=> acc == '0);

    assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        en |=> lim_q == $past(lim_q));

endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
    import por_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       below,
    input  logic       tmr_done,
    input  logic       trip,
    output por_state_e state,
    output por_cmd_t   cmd
);
    por_state_e state_nx;

    assign cmd = cmd_of(state, valid && !below);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:   if (valid && !below) state_nx = ST_TIMING;
            ST_TIMING: begin
                if (valid && below)  state_nx = ST_HOLD;
                else if (tmr_done)   state_nx = ST_RUN;
            end
            ST_RUN:    if (trip) state_nx = ST_HOLD;
            default:   state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nx;
    end

    assert_hold_below_R2: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD && !(valid && !below) |=> state == ST_HOLD);

    assert_release_via_timer_R3: assert property (@(posedge clk) disable iff (rst)
        state != ST_RUN && !(state == ST_TIMING && tmr_done) |=> state != ST_RUN);

    assert_abort_timing_R4: assert property (@(posedge clk) disable iff (rst)
        state == ST_TIMING && valid && below |=> state == ST_HOLD);

endmodule

// File: rtl/por_supervisor.sv
module por_supervisor
    import por_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int TIMER_W  = DEF_TIMER_W,
    parameter int ACC_W    = DEF_ACC_W,
    parameter int DECAY    = DEF_DECAY
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic [TIMER_W-1:0]  hold_cycles,
    input  logic [ACC_W-1:0]    trip_limit,
    output logic                reset_n
);
    logic                below;
    logic [SAMPLE_W-1:0] depth;
    logic                tmr_done;
    logic                trip;
    por_state_e          state;
    por_cmd_t            cmd;

    // Single comparison shared by both directions: no hysteresis
    assign below   = sample < threshold;
    assign depth   = below ? (threshold - sample) : '0;
    assign reset_n = (state == ST_RUN);

    por_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .valid    (sample_valid),
        .below    (below),
        .tmr_done (tmr_done),
        .trip     (trip),
        .state    (state),
        .cmd      (cmd)
    );

    por_hold_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (cmd.tmr_start),
        .run    (cmd.tmr_run),
        .length (hold_cycles),
        .done   (tmr_done)
    );

    por_dip_integrator #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .DECAY    (DECAY)
    ) u_integ (
        .clk   (clk),
        .rst   (rst),
        .clr   (cmd.integ_clr),
        .en    (cmd.integ_en),
        .valid (sample_valid),
        .below (below),
        .depth (depth),
        .limit (trip_limit),
        .trip  (trip)
    );

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !reset_n);

    assert_equal_is_above_R5: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD && sample_valid && sample == threshold |=> state == ST_TIMING);

    assert_trip_drops_R7: assert property (@(posedge clk) disable iff (rst)
        reset_n && trip |=> !reset_n);

endmodule

// File: tb/por_supervisor_bench.sv
module por_supervisor_bench;
    import por_pkg::*;

    localparam int SW = DEF_SAMPLE_W;
    localparam int TW = DEF_TIMER_W;
    localparam int AW = DEF_ACC_W;

    typedef struct packed {
        logic          v;
        logic [SW-1:0] s;
        logic          exp;
    } vec_t;

    // threshold 900, hold 3, limit 100, decay 1
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'd800,  1'b0},  // R2 below after reset
        '{1'b1, 12'd950,  1'b0},  // R3 timer starts
        '{1'b0, 12'd0,    1'b0},
        '{1'b1, 12'd850,  1'b0},  // R4 abort timing
        '{1'b1, 12'd900,  1'b0},  // R5 equal counts as above
        '{1'b0, 12'd0,    1'b0},
        '{1'b0, 12'd0,    1'b0},
        '{1'b0, 12'd0,    1'b1},  // R3 released after 3
        '{1'b1, 12'd860,  1'b1},  // R6 acc 40
        '{1'b1, 12'd860,  1'b1},  // acc 80
        '{1'b1, 12'd1000, 1'b1},  // acc 79
        '{1'b1, 12'd880,  1'b1},  // acc 99
        '{1'b1, 12'd899,  1'b0},  // R7 acc 100 trips
        '{1'b1, 12'd905,  1'b0},
        '{1'b0, 12'd0,    1'b0},
        '{1'b0, 12'd0,    1'b0},
        '{1'b0, 12'd0,    1'b1},
        '{1'b1, 12'd850,  1'b1},  // acc 50
        '{1'b1, 12'd950,  1'b1},  // acc 49
        '{1'b0, 12'd0,    1'b1},  // R6 invalid ignored
        '{1'b1, 12'd849,  1'b0},  // acc 100 trips
        '{1'b1, 12'd0,    1'b0}   // R2 power-down held low
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample = '0;
    logic [SW-1:0] threshold = 12'd900;
    logic [TW-1:0] hold_cycles = 16'd3;
    logic [AW-1:0] trip_limit = 18'd100;
    logic          reset_n;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    por_supervisor u_por_supervisor (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample       (sample),
        .threshold    (threshold),
        .hold_cycles  (hold_cycles),
        .trip_limit   (trip_limit),
        .reset_n      (reset_n)
    );

    task automatic step(input logic v, input logic [SW-1:0] s);
        sample_valid = v;
        sample       = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        total++;
        if (reset_n !== exp) begin
            fails++;
            $display("FAIL %s: reset_n=%0b expected %0b", tag, reset_n, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b1, threshold);
        step(1'b1, threshold);
        rst = 1'b0;
    endtask

    // start at the threshold, then idle until released
    task automatic bring_up(input int len);
        hold_cycles = TW'(len);
        step(1'b1, threshold);
        for (int i = 0; i < (len < 1 ? 1 : len); i++) step(1'b0, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not complete, reset_n=%0b expected completion", reset_n);
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk(1'b0, "R1 reset state low");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v, VECS[i].s);
            chk(VECS[i].exp, $sformatf("vector %0d (R2..R7)", i));
        end

        // R1: reset in the released state, accumulator cleared
        do_reset();
        bring_up(3);
        chk(1'b1, "R1 released before mid-run reset");
        step(1'b1, 12'd810);           // acc 90
        rst = 1'b1;
        step(1'b1, threshold);
        rst = 1'b0;
        chk(1'b0, "R1 mid-run reset drives low");
        bring_up(3);
        step(1'b1, 12'd880);           // 20 < 100 only if acc was cleared
        chk(1'b1, "R1 accumulator cleared by reset");

        // R3: zero length acts as one cycle
        do_reset();
        hold_cycles = '0;
        step(1'b1, 12'd1000);
        chk(1'b0, "R3 zero length, start edge");
        step(1'b0, '0);
        chk(1'b1, "R3 zero length released after one edge");

        // R3: long hold exact edge
        do_reset();
        hold_cycles = 16'd40;
        step(1'b1, 12'd1000);
        for (int i = 0; i < 39; i++) step(1'b0, '0);
        chk(1'b0, "R3 hold 40, one edge early");
        step(1'b0, '0);
        chk(1'b1, "R3 hold 40 released");

        // R8: hold length latched at start
        do_reset();
        hold_cycles = 16'd4;
        step(1'b1, 12'd1000);
        hold_cycles = 16'd1;
        for (int i = 0; i < 3; i++) step(1'b0, '0);
        chk(1'b0, "R8 hold length latched, still low");
        step(1'b0, '0);
        chk(1'b1, "R8 hold length latched, released");

        // R8: limit frozen while released
        do_reset();
        trip_limit = 18'd100;
        bring_up(2);
        trip_limit = 18'd10;
        step(1'b1, 12'd850);           // acc 50 < 100
        chk(1'b1, "R8 limit frozen, no trip at 50");
        step(1'b1, 12'd850);           // acc 100
        chk(1'b0, "R8 limit frozen, trip at 100");
        trip_limit = 18'd100;

        // R7: deep short dip trips at once
        do_reset();
        bring_up(2);
        step(1'b1, 12'd700);
        chk(1'b0, "R7 deep single dip trips");

        // R6: decay floors at zero
        do_reset();
        bring_up(2);
        for (int i = 0; i < 5; i++) step(1'b1, 12'd1200);
        step(1'b1, 12'd801);           // 99 < 100
        chk(1'b1, "R6 decay floored at zero");
        step(1'b1, 12'd1000);          // acc 98
        step(1'b1, 12'd898);           // acc 100
        chk(1'b0, "R6 accumulate after decay trips");

        // R9: saturation instead of wrap
        threshold  = 12'd4095;
        trip_limit = {AW{1'b1}};
        do_reset();
        bring_up(2);
        for (int i = 0; i < 64; i++) step(1'b1, '0);
        chk(1'b1, "R9 below limit after 64 deep samples");
        step(1'b1, '0);
        chk(1'b0, "R9 saturated accumulator trips");

        finish_run();
    end

endmodule